// File: doc/BRIEF.md
# Card Data Byte Buffer with Burst Service Requests

This block holds one 32-byte transmit buffer and one 32-byte receive buffer between a host bus and the data path of a memory-card controller. The host moves data one byte per access. The block asks for service in whole 32-byte blocks. A transmit request means "fill this buffer" and a receive request means "drain this buffer".

A mode input selects where those requests go. In DMA mode they drive the DMA request lines. In programmed-I/O mode they appear as interrupt status flags, and the host waits for a flag before it touches the matching buffer.

A transmit block shorter than 32 bytes does not start by itself. Software releases it with a one-cycle partially-full pulse. In DMA mode this pulse is normally given after the end-of-transfer interrupt for the last short descriptor. On the receive side, a block is handed to the host when it reaches 32 bytes or when the card side signals end of data.

Top module: `card_burst_buffer`

## Requirements
- R1: After reset the transmit request is active, the receive request is inactive, `card_tx_valid`, `partial_flag`, `tx_overrun` and `rx_underrun` are all 0, and `rx_rdata` reads 0.
- R2: The transmit request is active exactly while the transmit buffer holds no bytes. The first accepted host write drops it, and it stays low until the buffer has been released and fully consumed.
- R3: When the 32nd byte is written, the transmit buffer is released. `card_tx_valid` is then 1, and the card side reads the bytes on `card_tx_data` in write order, one byte per `card_tx_rd` cycle.
- R4: A `partial_set` pulse while the buffer holds 1 to 31 unreleased bytes releases the buffer and sets `partial_flag` to 1. A pulse while the buffer is empty has no effect.
- R5: When the card side consumes the last byte of a released buffer, `partial_flag` and `card_tx_valid` go to 0 and the transmit request returns on the next cycle.
- R6: A host write while the transmit buffer is full or released is ignored. It sets the sticky `tx_overrun` bit, which stays 1 until reset, and the stored bytes are unchanged.
- R7: The receive request becomes active once 32 bytes have arrived from the card. The host then reads them in arrival order on `rx_rdata`, which shows the next byte before each `rx_rd` cycle. The request drops after the last byte is read.
- R8: A `card_rx_end` pulse with 1 to 31 bytes collected activates the receive request for that shorter block. A pulse with no bytes collected has no effect.
- R9: A host read while no receive block is released returns 0 on `rx_rdata` and sets the sticky `rx_underrun` bit. A card write while a receive block is released is dropped.
- R10: With `dma_mode` = 1 the requests appear only on `dma_tx_req` and `dma_rx_req`. With `dma_mode` = 0 they appear only on `irq_tx_req` and `irq_rx_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_mode | input | 1 | 1 routes requests to DMA lines, 0 routes them to interrupt flags |
| tx_wr | input | 1 | Host byte write strobe into the transmit buffer |
| tx_wdata | input | 8 | Host write byte |
| partial_set | input | 1 | Software pulse that releases a short transmit block |
| rx_rd | input | 1 | Host byte read strobe from the receive buffer |
| rx_rdata | output | 8 | Next receive byte, or 0 when no block is released |
| card_tx_rd | input | 1 | Card side consumes one transmit byte |
| card_tx_data | output | 8 | Current transmit byte for the card side |
| card_tx_valid | output | 1 | Transmit buffer released and holding bytes |
| card_rx_wr | input | 1 | Card side writes one receive byte |
| card_rx_data | input | 8 | Receive byte from the card side |
| card_rx_end | input | 1 | Card side end-of-data indication |
| dma_tx_req | output | 1 | DMA request to fill the transmit buffer |
| dma_rx_req | output | 1 | DMA request to drain the receive buffer |
| irq_tx_req | output | 1 | Programmed-I/O flag: transmit buffer wants filling |
| irq_rx_req | output | 1 | Programmed-I/O flag: receive buffer wants draining |
| partial_flag | output | 1 | Released transmit block is short |
| tx_overrun | output | 1 | Sticky: write to a full or released transmit buffer |
| rx_underrun | output | 1 | Sticky: read with no released receive block |

## Verification
A wrong byte count or pointer shows at the ports within one cycle. It appears as a request that rises or falls one byte early or late, as a `card_tx_valid` that comes too soon, or as a wrong byte on `card_tx_data` or `rx_rdata` at the first misplaced position. A `partial_flag` or release state that is not cleared shows on the cycle after the last byte is consumed: the transmit request stays low and the next block is never asked for. Routing mistakes show immediately on the request line of the mode that should be silent.

// File: rtl/card_burst_buffer.sv
module card_burst_buffer #(
  parameter int DEPTH = 32,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dma_mode,
  input  logic         tx_wr,
  input  logic [W-1:0] tx_wdata,
  input  logic         partial_set,
  input  logic         rx_rd,
  output logic [W-1:0] rx_rdata,
  input  logic         card_tx_rd,
  output logic [W-1:0] card_tx_data,
  output logic         card_tx_valid,
  input  logic         card_rx_wr,
  input  logic [W-1:0] card_rx_data,
  input  logic         card_rx_end,
  output logic         dma_tx_req,
  output logic         dma_rx_req,
  output logic         irq_tx_req,
  output logic         irq_rx_req,
  output logic         partial_flag,
  output logic         tx_overrun,
  output logic         rx_underrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [W-1:0]  txm [DEPTH];
  logic [W-1:0]  rxm [DEPTH];
  logic [CW-1:0] tx_cnt, tx_rp, rx_cnt, rx_rp;
  logic          tx_part, rx_done;

  logic tx_rel, wr_ok, rd_ok, tx_last, part_ok;
  logic rx_rdy, cw_ok, end_ok, hr_ok, rx_last;
  logic tx_req, rx_req;

  assign tx_rel  = (tx_cnt == FULL) | tx_part;
  assign wr_ok   = tx_wr & ~tx_rel;
  assign rd_ok   = card_tx_rd & tx_rel;
  assign tx_last = rd_ok & ((tx_rp + ONE) == tx_cnt);
  assign part_ok = partial_set & ~tx_rel & ((tx_cnt != '0) | wr_ok);

  assign rx_rdy  = (rx_cnt == FULL) | rx_done;
  assign cw_ok   = card_rx_wr & ~rx_rdy;
  assign end_ok  = card_rx_end & ~rx_rdy & ((rx_cnt != '0) | cw_ok);
  assign hr_ok   = rx_rd & rx_rdy;
  assign rx_last = hr_ok & ((rx_rp + ONE) == rx_cnt);

  assign tx_req = (tx_cnt == '0);
  assign rx_req = rx_rdy;

  assign dma_tx_req = dma_mode & tx_req;
  assign irq_tx_req = ~dma_mode & tx_req;
  assign dma_rx_req = dma_mode & rx_req;
  assign irq_rx_req = ~dma_mode & rx_req;

  assign card_tx_valid = tx_rel;
  assign card_tx_data  = txm[tx_rp[AW-1:0]];
  assign partial_flag  = tx_part;
  assign rx_rdata      = rx_rdy ? rxm[rx_rp[AW-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (wr_ok) txm[tx_cnt[AW-1:0]] <= tx_wdata;
    if (cw_ok) rxm[rx_cnt[AW-1:0]] <= card_rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_cnt     <= '0;
      tx_rp      <= '0;
      tx_part    <= 1'b0;
      tx_overrun <= 1'b0;
    end else begin
      if (wr_ok) tx_cnt <= tx_cnt + ONE;
      if (tx_wr & tx_rel) tx_overrun <= 1'b1;
      if (part_ok) tx_part <= 1'b1;
      if (rd_ok) begin
        if (tx_last) begin
          tx_cnt  <= '0;
          tx_rp   <= '0;
          tx_part <= 1'b0;
        end else begin
          tx_rp <= tx_rp + ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_cnt      <= '0;
      rx_rp       <= '0;
      rx_done     <= 1'b0;
      rx_underrun <= 1'b0;
    end else begin
      if (cw_ok) rx_cnt <= rx_cnt + ONE;
      if (end_ok) rx_done <= 1'b1;
      if (rx_rd & ~rx_rdy) rx_underrun <= 1'b1;
      if (hr_ok) begin
        if (rx_last) begin
          rx_cnt  <= '0;
          rx_rp   <= '0;
          rx_done <= 1'b0;
        end else begin
          rx_rp <= rx_rp + ONE;
        end
      end
    end
  end

  a_r2_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && (dma_tx_req || irq_tx_req)) |=> !(dma_tx_req || irq_tx_req));

  a_r3_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (card_tx_valid && !card_tx_rd) |=> (card_tx_valid && $stable(card_tx_data)));

  a_r5_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (card_tx_valid && card_tx_rd && tx_last) |=> (!partial_flag && !card_tx_valid && (dma_tx_req || irq_tx_req)));

  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && card_tx_valid) |=> tx_overrun);

  a_r9_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !(dma_rx_req || irq_rx_req)) |=> rx_underrun);

  a_r7_full_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (card_rx_wr && !rx_rdy && (rx_cnt == FULL - ONE)) |=> (dma_rx_req || irq_rx_req));

  a_r10_released_no_tx_req: assert property (@(posedge clk) disable iff (!rst_n)
    card_tx_valid |-> !(dma_tx_req || irq_tx_req));
endmodule

// File: tb/card_burst_buffer_test.sv
module card_burst_buffer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dma_mode = 1'b0;
  logic tx_wr = 1'b0;
  logic [7:0] tx_wdata = '0;
  logic partial_set = 1'b0;
  logic rx_rd = 1'b0;
  logic [7:0] rx_rdata;
  logic card_tx_rd = 1'b0;
  logic [7:0] card_tx_data;
  logic card_tx_valid;
  logic card_rx_wr = 1'b0;
  logic [7:0] card_rx_data = '0;
  logic card_rx_end = 1'b0;
  logic dma_tx_req, dma_rx_req, irq_tx_req, irq_rx_req;
  logic partial_flag, tx_overrun, rx_underrun;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  card_burst_buffer uut (
    .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .partial_set(partial_set),
    .rx_rd(rx_rd), .rx_rdata(rx_rdata),
    .card_tx_rd(card_tx_rd), .card_tx_data(card_tx_data), .card_tx_valid(card_tx_valid),
    .card_rx_wr(card_rx_wr), .card_rx_data(card_rx_data), .card_rx_end(card_rx_end),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req),
    .irq_tx_req(irq_tx_req), .irq_rx_req(irq_rx_req),
    .partial_flag(partial_flag), .tx_overrun(tx_overrun), .rx_underrun(rx_underrun)
  );

  localparam int NV = 6;
  localparam int VLEN [NV] = '{32, 2, 9, 31, 1, 32};
  localparam bit VDMA [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam bit VPRT [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_wdata = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic pulse_partial;
    @(negedge clk); partial_set = 1'b1;
    @(negedge clk); partial_set = 1'b0;
  endtask

  task automatic card_pull(output logic [7:0] d);
    @(negedge clk); #1 d = card_tx_data; card_tx_rd = 1'b1;
    @(negedge clk); card_tx_rd = 1'b0;
  endtask

  task automatic card_push(input logic [7:0] d);
    @(negedge clk); card_rx_wr = 1'b1; card_rx_data = d;
    @(negedge clk); card_rx_wr = 1'b0;
  endtask

  task automatic pulse_end;
    @(negedge clk); card_rx_end = 1'b1;
    @(negedge clk); card_rx_end = 1'b0;
  endtask

  task automatic host_read(output logic [7:0] d);
    @(negedge clk); #1 d = rx_rdata; rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 irq_tx_req", irq_tx_req, 1);
    chk("R1 rx req", dma_rx_req | irq_rx_req, 0);
    chk("R1 card_tx_valid", card_tx_valid, 0);
    chk("R1 partial_flag", partial_flag, 0);
    chk("R1 sticky bits", {tx_overrun, rx_underrun}, 0);
    chk("R1 rx_rdata", rx_rdata, 0);

    for (int v = 0; v < NV; v++) begin
      dma_mode = VDMA[v];
      @(negedge clk); #1;
      chk("R10 dma_tx_req", dma_tx_req, VDMA[v]);
      chk("R10 irq_tx_req", irq_tx_req, !VDMA[v]);
      for (int k = 0; k < VLEN[v]; k++) begin
        host_write(8'(v * 40 + k + 1));
        #1;
        if (k == 0) chk("R2 tx req after first write", dma_tx_req | irq_tx_req, 0);
      end
      if (VLEN[v] < 32) begin
        #1 chk("R4 not released before pulse", card_tx_valid, 0);
        pulse_partial;
      end
      #1;
      chk("R4 partial_flag", partial_flag, VPRT[v]);
      chk("R3 card_tx_valid", card_tx_valid, 1);
      chk("R2 tx req low while released", dma_tx_req | irq_tx_req, 0);
      for (int k = 0; k < VLEN[v]; k++) begin
        card_pull(d);
        chk("R3 tx byte order", d, (v * 40 + k + 1) % 256);
      end
      #1;
      chk("R5 partial cleared", partial_flag, 0);
      chk("R5 valid cleared", card_tx_valid, 0);
      chk("R5 tx req back", VDMA[v] ? dma_tx_req : irq_tx_req, 1);

      for (int k = 0; k < VLEN[v]; k++) card_push(8'(v * 7 + k + 100));
      if (VLEN[v] < 32) begin
        #1 chk("R8 no rx req before end", dma_rx_req | irq_rx_req, 0);
        pulse_end;
      end
      #1;
      chk("R10 dma_rx_req", dma_rx_req, VDMA[v]);
      chk("R10 irq_rx_req", irq_rx_req, !VDMA[v]);
      for (int k = 0; k < VLEN[v]; k++) begin
        host_read(d);
        chk(VLEN[v] < 32 ? "R8 rx short byte" : "R7 rx byte order", d, (v * 7 + k + 100) % 256);
      end
      #1 chk("R7 rx req drops", dma_rx_req | irq_rx_req, 0);
    end

    dma_mode = 1'b0;
    #1 chk("R6 no overrun yet", tx_overrun, 0);
    for (int k = 0; k < 32; k++) host_write(8'(k + 50));
    host_write(8'hEE);
    #1 chk("R6 overrun set", tx_overrun, 1);
    card_pull(d);
    chk("R6 first byte unchanged", d, 50);
    for (int k = 1; k < 32; k++) card_pull(d);
    chk("R6 last byte unchanged", d, 81);
    #1 chk("R6 overrun sticky", tx_overrun, 1);
    chk("R5 empty after full drain", card_tx_valid, 0);

    pulse_partial;
    #1 chk("R4 pulse on empty ignored", card_tx_valid, 0);
    chk("R4 flag stays low", partial_flag, 0);
    chk("R2 tx req still high", irq_tx_req, 1);

    pulse_end;
    #1 chk("R8 end with no bytes ignored", irq_rx_req, 0);

    chk("R9 no underrun yet", rx_underrun, 0);
    host_read(d);
    chk("R9 empty read zero", d, 0);
    #1 chk("R9 underrun set", rx_underrun, 1);

    for (int k = 0; k < 32; k++) card_push(8'(k + 200));
    card_push(8'h11);
    host_read(d);
    chk("R9 first byte kept", d, 200);
    for (int k = 1; k < 32; k++) host_read(d);
    chk("R9 last byte not replaced", d, 231);
    #1 chk("R9 dropped byte not stored", irq_rx_req, 0);
    host_read(d);
    chk("R9 read after drain zero", d, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule